// File: doc/BRIEF.md
# Level-Sensitive Interrupt Combiner

This block gathers ten peripheral interrupt lines and presents them to a processor as two request outputs: a normal request and a fast request. Each source is qualified by a per-source enable bit, can have its active level inverted, and can be replaced by a software-written test value so that interrupt handling code can be exercised without the peripheral. Software uses a small 32-bit register bus with byte offsets, a write strobe and a combinational read port.

The enable mask is never written directly. One offset sets the enable bits whose data bits are 1, and a second offset clears them. Two software contexts can therefore each change their own sources without a read-modify-write race. Sources are level-sensitive and nothing is latched. A pending bit follows its input for as long as the input stays active and enabled. The two request outputs are registered, so each follows the enabled pending set one clock later.

Top module: `lvl_irq_ctrl`

## Requirements
- R1: After reset, the enable mask, the route, polarity, test-value and test-select registers are all 0, both request outputs are 0 and the status offset reads 0.
- R2: A write to offset 0x08 sets the enable bit of every source whose data bit is 1. All other enable bits keep their value.
- R3: A write to offset 0x0C clears the enable bit of every source whose data bit is 1. All other enable bits keep their value.
- R4: A read of offset 0x00 returns, in bits 9..0, the active state of each source ANDed with its enable bit. The value follows the inputs level by level and is not held once an input goes inactive.
- R5: Polarity register at offset 0x18: bit i = 0 means pin i is active when high; bit i = 1 means it is active when low.
- R6: Route register at offset 0x14: bit i = 0 sends source i to the normal request, and bit i = 1 sends it to the fast request. Each output is the OR of the enabled active sources routed to it, as sampled at the previous rising clock edge.
- R7: When bit i of the test-select register at offset 0x28 is 1, the active state of source i is bit i of the test-value register at offset 0x24, and pin i and polarity bit i have no effect. When the select bit is 0, only the pin (after polarity) drives the source.
- R8: Reads of offset 0x08 or 0x0C return the enable mask. Reads of 0x14, 0x18, 0x24 and 0x28 return their registers. Reads of any other offset return 0.
- R9: Only bits 9..0 are stored. Write data bits 31..10 are ignored, and read data bits 31..10 are always 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Byte offset of the register access |
| bus_we | input | 1 | Write strobe, one write per cycle in which it is high |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| src_in | input | 10 | Peripheral interrupt lines, one per source |
| irq_norm_o | output | 1 | Registered normal request |
| irq_fast_o | output | 1 | Registered fast request |

## Verification
A walking single source is driven on each pin under both routes and both polarities. This exposes crossed bit lanes, inverted polarity and a swapped route. All-ones and all-zeros patterns, and pseudo-random patterns with random enable, route, polarity and test settings, separate the OR reduction from AND-style or latched logic. Dropping an input after it was seen must clear the status, which rules out a sticky pending bit. Set and clear writes with partial masks on top of a known mask show whether unwritten bits are kept. Upper-bit writes and reads of unmapped offsets show that nothing outside bits 9..0 or the listed offsets is stored.

// File: rtl/lic_pkg.sv
// Package: shared sizes and register offsets of the level interrupt combiner.
// Assumes byte offsets on an 8-bit address and a 32-bit data bus.
package lic_pkg;
    localparam int N_SRC  = 10;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 8;

    localparam logic [ADDR_W-1:0] OFF_STATUS = 8'h00;
    localparam logic [ADDR_W-1:0] OFF_SET    = 8'h08;
    localparam logic [ADDR_W-1:0] OFF_CLR    = 8'h0C;
    localparam logic [ADDR_W-1:0] OFF_ROUTE  = 8'h14;
    localparam logic [ADDR_W-1:0] OFF_POL    = 8'h18;
    localparam logic [ADDR_W-1:0] OFF_TVAL   = 8'h24;
    localparam logic [ADDR_W-1:0] OFF_TSEL   = 8'h28;
endpackage

// File: rtl/lic_regs.sv
// Module: configuration storage of the combiner.
// Holds the enable mask, which changes only through the set and clear
// strobe offsets, plus the route, polarity, test value and test select.
// Assumes at most one write per cycle. Upper write data bits are dropped.
module lic_regs
    import lic_pkg::*;
#(
    parameter int N  = N_SRC,
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [N-1:0]  en_q,
    output logic [N-1:0]  route_q,
    output logic [N-1:0]  pol_q,
    output logic [N-1:0]  tval_q,
    output logic [N-1:0]  tsel_q
);
    logic [N-1:0] wbits;
    assign wbits = wdata[N-1:0];

    // Enable mask: set strobe ORs bits in, clear strobe removes them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0;
        end else if (wr_en && addr == OFF_SET) begin
            en_q <= en_q | wbits;
        end else if (wr_en && addr == OFF_CLR) begin
            en_q <= en_q & ~wbits;
        end
    end

    // Plain configuration registers written in full at their own offsets.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            route_q <= '0;
            pol_q   <= '0;
            tval_q  <= '0;
            tsel_q  <= '0;
        end else if (wr_en) begin
            case (addr)
                OFF_ROUTE: route_q <= wbits;
                OFF_POL:   pol_q   <= wbits;
                OFF_TVAL:  tval_q  <= wbits;
                OFF_TSEL:  tsel_q  <= wbits;
                default: ;
            endcase
        end
    end

    AST_SET_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFF_SET) |=>
            ((en_q & ~$past(wbits)) == ($past(en_q) & ~$past(wbits)))
            && ((en_q & $past(wbits)) == $past(wbits))); // R2
    AST_CLR_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFF_CLR) |=>
            ((en_q & ~$past(wbits)) == ($past(en_q) & ~$past(wbits)))
            && ((en_q & $past(wbits)) == '0)); // R3
    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(en_q)); // R2
    AST_UPPER_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFF_ROUTE && (|wdata[DW-1:N])) |=>
            (route_q == $past(wbits))); // R9
endmodule

// File: rtl/lic_src.sv
// Module: per-source conditioning.
// For each source, picks either the test value or the pin after its
// polarity, then qualifies the result with the enable bit. Purely
// combinational, so a pending bit follows its input level directly.
module lic_src
    import lic_pkg::*;
#(
    parameter int N = N_SRC
) (
    input  logic [N-1:0] pin,
    input  logic [N-1:0] pol,
    input  logic [N-1:0] tval,
    input  logic [N-1:0] tsel,
    input  logic [N-1:0] en,
    output logic [N-1:0] pend
);
    for (genvar i = 0; i < N; i++) begin : g_src
        logic active;
        // Source i: test override or polarity-corrected pin.
        assign active  = tsel[i] ? tval[i] : (pin[i] ^ pol[i]);
        assign pend[i] = active & en[i];
    end
endmodule

// File: rtl/lic_route.sv
// Module: request output stage.
// ORs the pending sources routed to each output and registers both
// results, which gives one clock of latency from pending to request.
module lic_route
    import lic_pkg::*;
#(
    parameter int N = N_SRC
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pend,
    input  logic [N-1:0] route,
    output logic         irq_norm,
    output logic         irq_fast
);
    logic [N-1:0] to_norm;
    logic [N-1:0] to_fast;
    assign to_norm = pend & ~route;
    assign to_fast = pend & route;

    // Register the two OR reductions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_norm <= 1'b0;
            irq_fast <= 1'b0;
        end else begin
            irq_norm <= |to_norm;
            irq_fast <= |to_fast;
        end
    end
endmodule

// File: rtl/lvl_irq_ctrl.sv
// Module: top of the level interrupt combiner.
// Connects register storage, source conditioning and the output stage,
// and provides the combinational read port. Assumes a single-master
// register bus that reads without side effects.
module lvl_irq_ctrl
    import lic_pkg::*;
#(
    parameter int N  = N_SRC,
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_we,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic [N-1:0]  src_in,
    output logic          irq_norm_o,
    output logic          irq_fast_o
);
    localparam int PAD = DW - N;

    logic [N-1:0] en_q, route_q, pol_q, tval_q, tsel_q, pend;
    logic [N-1:0] rd_sel;

    lic_regs #(.N(N), .DW(DW), .AW(AW)) regs_i (
        .clk(clk), .rst_n(rst_n), .wr_en(bus_we), .addr(bus_addr),
        .wdata(bus_wdata), .en_q(en_q), .route_q(route_q), .pol_q(pol_q),
        .tval_q(tval_q), .tsel_q(tsel_q)
    );

    lic_src #(.N(N)) src_i (
        .pin(src_in), .pol(pol_q), .tval(tval_q), .tsel(tsel_q),
        .en(en_q), .pend(pend)
    );

    lic_route #(.N(N)) route_i (
        .clk(clk), .rst_n(rst_n), .pend(pend), .route(route_q),
        .irq_norm(irq_norm_o), .irq_fast(irq_fast_o)
    );

    // Read mux: pick the addressed value, unmapped offsets give zero.
    always_comb begin
        case (bus_addr)
            OFF_STATUS:       rd_sel = pend;
            OFF_SET, OFF_CLR: rd_sel = en_q;
            OFF_ROUTE:        rd_sel = route_q;
            OFF_POL:          rd_sel = pol_q;
            OFF_TVAL:         rd_sel = tval_q;
            OFF_TSEL:         rd_sel = tsel_q;
            default:          rd_sel = '0;
        endcase
    end
    assign bus_rdata = {{PAD{1'b0}}, rd_sel};

    // Pending sources never show outside the enable mask.
    always_comb begin
        AST_STATUS_MASKED: assert ((pend & ~en_q) == '0); // R4
    end

    AST_NORM_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_norm_o |-> $past(|(pend & ~route_q))); // R6
    AST_FAST_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(route_q == '0) |-> !irq_fast_o); // R6
    AST_FAST_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_fast_o |-> $past(|(pend & route_q))); // R6
endmodule

// File: tb/lvl_irq_ctrl_tb.sv
// Bench: sweeps single sources, full patterns and pseudo-random
// configurations against a model computed from the requirements.
module lvl_irq_ctrl_tb_top;
    localparam int N = 10;
    localparam logic [31:0] ALLM = 32'h3FF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [9:0]  src_in = '0;
    logic        irq_norm_o, irq_fast_o;

    int checks = 0;
    int fails = 0;
    logic [9:0] m_en = '0, m_route = '0, m_pol = '0, m_tval = '0, m_tsel = '0;
    logic [31:0] lfsr = 32'h1ACE_B00C;

    always #10 clk = ~clk;

    lvl_irq_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_in(src_in),
        .irq_norm_o(irq_norm_o), .irq_fast_o(irq_fast_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
        case (a)
            8'h08: m_en = m_en | d[9:0];
            8'h0C: m_en = m_en & ~d[9:0];
            8'h14: m_route = d[9:0];
            8'h18: m_pol = d[9:0];
            8'h24: m_tval = d[9:0];
            8'h28: m_tsel = d[9:0];
            default: ;
        endcase
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    function automatic logic [9:0] exp_pend();
        logic [9:0] act;
        act = (m_tsel & m_tval) | (~m_tsel & (src_in ^ m_pol));
        return act & m_en;
    endfunction

    // Checks status immediately and both requests after one rising edge.
    task automatic check_all(input string req);
        logic [31:0] d;
        logic [9:0] p;
        p = exp_pend();
        rd(8'h00, d);
        chk(req, d, {22'b0, p});
        @(posedge clk);
        @(negedge clk);
        chk(req, {31'b0, irq_norm_o}, {31'b0, |(p & ~m_route)});
        chk(req, {31'b0, irq_fast_o}, {31'b0, |(p & m_route)});
    endtask

    function automatic logic [31:0] nxt(input logic [31:0] s);
        return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
    endfunction

    initial begin
        #(20 * 200000);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state of every readable offset and both outputs.
        src_in = 10'h3FF;
        rd(8'h08, d); chk("R1", d, 0);
        rd(8'h14, d); chk("R1", d, 0);
        rd(8'h18, d); chk("R1", d, 0);
        rd(8'h24, d); chk("R1", d, 0);
        rd(8'h28, d); chk("R1", d, 0);
        rd(8'h00, d); chk("R1", d, 0);
        chk("R1", {30'b0, irq_norm_o, irq_fast_o}, 0);

        // R2, R3: partial set and clear masks keep unwritten bits.
        wr(8'h08, 32'h0F0); rd(8'h08, d); chk("R2", d, 32'h0F0);
        wr(8'h08, 32'h303); rd(8'h08, d); chk("R2", d, 32'h3F3);
        wr(8'h0C, 32'h0A1); rd(8'h0C, d); chk("R3", d, 32'h352);
        wr(8'h08, 32'h000); rd(8'h08, d); chk("R2", d, 32'h352);
        wr(8'h0C, 32'h000); rd(8'h0C, d); chk("R3", d, 32'h352);
        wr(8'h0C, ALLM);    rd(8'h08, d); chk("R3", d, 0);

        // R9: upper data bits are dropped and read as zero.
        wr(8'h14, 32'hFFFF_FC00); rd(8'h14, d); chk("R9", d, 0);
        wr(8'h08, 32'hFFFF_FFFF); rd(8'h08, d); chk("R9", d, ALLM);
        wr(8'h18, 32'hA5A5_A5A5); rd(8'h18, d); chk("R9", d, 32'h1A5);
        wr(8'h24, 32'h8000_0155); rd(8'h24, d); chk("R8", d, 32'h155);
        wr(8'h28, 32'h0000_02AA); rd(8'h28, d); chk("R8", d, 32'h2AA);
        // R8: unmapped offsets read zero, a write there changes nothing.
        wr(8'h04, ALLM); rd(8'h04, d); chk("R8", d, 0);
        rd(8'h10, d); chk("R8", d, 0);
        rd(8'h2C, d); chk("R8", d, 0);
        rd(8'h08, d); chk("R8", d, ALLM);
        wr(8'h18, 0); wr(8'h24, 0); wr(8'h28, 0);

        // R4, R6: walking source on each pin, both routes.
        for (int r = 0; r < 2; r++) begin
            wr(8'h14, r ? ALLM : 0);
            for (int i = 0; i < N; i++) begin
                src_in = 10'(1 << i);
                check_all(r ? "R6" : "R4");
            end
        end
        // R4: level behaviour, status drops with the input.
        src_in = 10'h3FF; check_all("R4");
        src_in = 10'h000; check_all("R4");
        // R5: walking polarity with pins all low.
        wr(8'h14, 32'h155);
        for (int i = 0; i < N; i++) begin
            wr(8'h18, 32'(1 << i));
            check_all("R5");
        end
        src_in = 10'h3FF; check_all("R5");
        // R7: test select overrides pins and polarity per source.
        wr(8'h18, 32'h0F0);
        for (int i = 0; i < N; i++) begin
            wr(8'h28, 32'(1 << i));
            wr(8'h24, 0);    check_all("R7");
            wr(8'h24, ALLM); check_all("R7");
        end
        // R6: pseudo-random configurations and patterns.
        for (int k = 0; k < 300; k++) begin
            lfsr = nxt(lfsr);
            case (lfsr[2:0])
                3'd0: wr(8'h08, {22'b0, lfsr[17:8]});
                3'd1: wr(8'h0C, {22'b0, lfsr[17:8]});
                3'd2: wr(8'h14, {22'b0, lfsr[17:8]});
                3'd3: wr(8'h18, {22'b0, lfsr[17:8]});
                3'd4: wr(8'h24, {22'b0, lfsr[17:8]});
                3'd5: wr(8'h28, {22'b0, lfsr[13:8] == 0 ? lfsr[17:8] : 10'h0});
                default: ;
            endcase
            @(negedge clk);
            src_in = lfsr[27:18];
            check_all("R6");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule